// File: doc/BRIEF.md
# Multiplexed-Address Strobe-Driven Memory Array

This block models a conventional strobe-driven dynamic memory on top of an internal register array. The block runs on a fast system clock and treats its interface pins as asynchronous. Three active-low strobes drive it: a row strobe, a column strobe and a write enable. It also has one address bus that carries the row and column addresses at different times, a data input and a data output with an output-enable flag. All strobes and bus inputs are resynchronised, and the block acts on the edges it detects after the synchroniser.

A falling row strobe opens a row, which copies the whole row into a row buffer. Column strobes then read or write single locations in that buffer. The buffer is stored back into the array when the row strobe rises. Several column cycles may be made on one open row (page access). A row strobe cycle with no column activity refreshes a row. If the column strobe is already low when the row strobe falls, the block runs a refresh cycle on a row chosen by an internal counter and ignores the address bus.

Top module: `mux_dram`

## Requirements
- R1: While reset is low and just after its release, `dout_en` is 0 and `dout` is 0, and no row is open.
- R2: A falling `ras_n` while `cas_n` is high takes the row address from `addr[ROW_BITS-1:0]` and loads that row into the row buffer. Later changes on `addr` do not change which row is open.
- R3: When `cas_n` falls with a row open and `we_n` high, the column `addr[COL_BITS-1:0]` of the buffer is driven on `dout` and `dout_en` goes to 1. This happens at the (SYNC_STAGES+1)th rising clock edge that sees the new strobe level.
- R4: When `cas_n` falls with a row open and `we_n` low, `din` is written into the buffer at that column and `dout_en` stays 0. A later read of the same column on the same open row returns the written value.
- R5: A rising `cas_n` or `ras_n` clears `dout_en`. `dout` is 0 whenever `dout_en` is 0.
- R6: A rising `ras_n` on an open row stores the whole buffer back into that row. A later opening of the row returns the values written before. Other rows are unaffected.
- R7: Any number of column cycles with different columns may be made while `ras_n` stays low. All of them act on the one open row.
- R8: A `ras_n` low pulse with no `cas_n` activity leaves `dout_en` at 0 and keeps the contents of the row.
- R9: If `cas_n` is low when `ras_n` falls, the row comes from the internal refresh counter and `addr` is ignored. No data moves and `dout_en` stays 0. The cycle ends only when both strobes are high again, and stored contents are preserved.
- R10: The refresh counter advances by exactly one, modulo the row count, when each counter-driven refresh cycle ends. It changes at no other time.
- R11: Column strobe pulses while no row is open produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, sampled at the column strobe fall |
| addr | input | ADDR_W | Shared row/column address bus |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, 0 when not enabled |
| dout_en | output | 1 | High only during a read column cycle |

## Verification
On every cycle the checker checks the following. The output is quiet whenever the enable is low. The enable is high only while a normally opened row is in use, and it rises only after a detected column fall with write enable high. A write column cycle never raises it. The refresh counter changes only by one step and only as a counter-driven refresh ends. Whether data really survives a write-back, a refresh of either kind and a full wrap of the refresh counter, and whether the address bus is truly ignored once latched, can only be shown by the bench scenarios that reopen rows and read them back.

// File: rtl/mux_dram_pkg.sv
package mux_dram_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_OPEN = 2'd1,
      ST_CBR  = 2'd2
   } dram_state_t;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mux_dram_sync.sv
module mux_dram_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);

   logic [W-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign d_out = chain[STAGES-1];

endmodule

// File: rtl/mux_dram_edge.sv
module mux_dram_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic s_ras_n,
   input  logic s_cas_n,
   output logic ras_fall,
   output logic ras_rise,
   output logic cas_fall,
   output logic cas_rise
);

   logic prev_ras_n;
   logic prev_cas_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_ras_n <= 1'b1;
         prev_cas_n <= 1'b1;
      end else begin
         prev_ras_n <= s_ras_n;
         prev_cas_n <= s_cas_n;
      end
   end

   assign ras_fall = prev_ras_n  & ~s_ras_n;
   assign ras_rise = ~prev_ras_n & s_ras_n;
   assign cas_fall = prev_cas_n  & ~s_cas_n;
   assign cas_rise = ~prev_cas_n & s_cas_n;

endmodule

// File: rtl/mux_dram_refcnt.sv
module mux_dram_refcnt #(
   parameter int ROW_BITS = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv,
   output logic [ROW_BITS-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (adv) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/mux_dram_array.sv
module mux_dram_array #(
   parameter int ROW_BITS = 10,
   parameter int ROW_W    = 1024
) (
   input  logic                clk,
   input  logic [ROW_BITS-1:0] rd_row,
   output logic [ROW_W-1:0]    rd_data,
   input  logic                wr_en,
   input  logic [ROW_BITS-1:0] wr_row,
   input  logic [ROW_W-1:0]    wr_data
);

   localparam int ROWS = 1 << ROW_BITS;

   logic [ROW_W-1:0] cells [ROWS];

   assign rd_data = cells[rd_row];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_row] <= wr_data;
   end

endmodule

// File: rtl/mux_dram.sv
module mux_dram
   import mux_dram_pkg::*;
#(
   parameter int ROW_BITS    = 10,
   parameter int COL_BITS    = 10,
   parameter int DATA_W      = 1,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = max_int(ROW_BITS, COL_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   localparam int COLS  = 1 << COL_BITS;
   localparam int ROW_W = COLS * DATA_W;
   localparam int BUS_W = ADDR_W + DATA_W;

   if (ROW_BITS < 1 || ROW_BITS > 12) begin : g_bad_rows
      $error("mux_dram: ROW_BITS must lie in 1..12");
   end
   if (COL_BITS < 1 || COL_BITS > 12) begin : g_bad_cols
      $error("mux_dram: COL_BITS must lie in 1..12");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("mux_dram: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mux_dram: SYNC_STAGES must be at least 2");
   end

   // synchronised pins
   logic              s_ras_n, s_cas_n, s_we_n;
   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_din;

   mux_dram_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_strobe (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({ras_n, cas_n, we_n}),
      .d_out ({s_ras_n, s_cas_n, s_we_n})
   );

   mux_dram_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({addr, din}),
      .d_out ({s_addr, s_din})
   );

   logic ras_fall, ras_rise, cas_fall, cas_rise;

   mux_dram_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_ras_n  (s_ras_n),
      .s_cas_n  (s_cas_n),
      .ras_fall (ras_fall),
      .ras_rise (ras_rise),
      .cas_fall (cas_fall),
      .cas_rise (cas_rise)
   );

   // control state
   dram_state_t         state;
   logic [ROW_BITS-1:0] row_q;
   logic [ROW_BITS-1:0] ref_row;
   logic [ROW_BITS-1:0] sel_row;
   logic [COL_BITS-1:0] col;
   logic [ROW_W-1:0]    rowbuf;
   logic [ROW_W-1:0]    arr_rd;
   logic                arr_we;
   logic                cbr_done;
   logic                col_wr;
   logic                col_rd;

   assign col      = s_addr[COL_BITS-1:0];
   assign sel_row  = s_cas_n ? s_addr[ROW_BITS-1:0] : ref_row;
   assign cbr_done = (state == ST_CBR) && s_ras_n && s_cas_n;
   assign col_wr   = (state == ST_OPEN) && !ras_rise && cas_fall && !s_we_n;
   assign col_rd   = (state == ST_OPEN) && !ras_rise && cas_fall &&  s_we_n;
   assign arr_we   = ((state == ST_OPEN) && ras_rise) || cbr_done;

   mux_dram_refcnt #(.ROW_BITS(ROW_BITS)) u_refcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (cbr_done),
      .cnt   (ref_row)
   );

   mux_dram_array #(.ROW_BITS(ROW_BITS), .ROW_W(ROW_W)) u_array (
      .clk     (clk),
      .rd_row  (sel_row),
      .rd_data (arr_rd),
      .wr_en   (arr_we),
      .wr_row  (row_q),
      .wr_data (rowbuf)
   );

   // state sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         row_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (ras_fall) begin
                  row_q <= sel_row;
                  state <= s_cas_n ? ST_OPEN : ST_CBR;
               end
            end
            ST_OPEN: begin
               if (ras_rise) state <= ST_IDLE;
            end
            ST_CBR: begin
               if (cbr_done) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // row buffer: loaded on open, patched by column writes
   always_ff @(posedge clk) begin
      if ((state == ST_IDLE) && ras_fall) begin
         rowbuf <= arr_rd;
      end else if (col_wr) begin
         rowbuf[int'(col)*DATA_W +: DATA_W] <= s_din;
      end
   end

   // read data path
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout    <= '0;
         dout_en <= 1'b0;
      end else if (col_rd) begin
         dout    <= rowbuf[int'(col)*DATA_W +: DATA_W];
         dout_en <= 1'b1;
      end else if (col_wr || ras_rise || cas_rise || (state != ST_OPEN)) begin
         dout    <= '0;
         dout_en <= 1'b0;
      end
   end

endmodule

// File: rtl/mux_dram_chk.sv
module mux_dram_chk
   import mux_dram_pkg::*;
#(
   parameter int ROW_BITS = 10,
   parameter int DATA_W   = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [DATA_W-1:0]   dout,
   input logic                dout_en,
   input dram_state_t         state,
   input logic [ROW_BITS-1:0] ref_row,
   input logic                cas_fall,
   input logic                ras_rise,
   input logic                s_we_n
);

   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> (dout == '0)); // R5

   AST_OE_NEEDS_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> (state == ST_OPEN)); // R3

   AST_OE_RISES_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_en) |-> $past(cas_fall && s_we_n)); // R3

   AST_WRITE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OPEN && cas_fall && !s_we_n && !ras_rise) |=> !dout_en); // R4

   AST_CLOSE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OPEN && ras_rise) |=> (state == ST_IDLE) && !dout_en); // R6

   AST_CBR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CBR) |-> !dout_en); // R9

   AST_REF_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_row != $past(ref_row)) |-> (ref_row == ROW_BITS'($past(ref_row) + 1'b1))); // R10

   AST_REF_ONLY_CBR: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_row != $past(ref_row)) |-> ($past(state) == ST_CBR)); // R10

endmodule

bind mux_dram mux_dram_chk #(.ROW_BITS(ROW_BITS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/mux_dram_tb.sv
module mux_dram_tb;

   localparam int ROW_BITS = 10;
   localparam int COL_BITS = 10;
   localparam int DATA_W   = 1;
   localparam int SYNC     = 2;
   localparam int ROWS     = 1 << ROW_BITS;
   localparam int COLS     = 1 << COL_BITS;
   localparam int ADDR_W   = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic              din = 1'b0;
   logic              dout, dout_en;

   always #5 clk = ~clk;

   mux_dram #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W),
              .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
   );

   int    vectors = 0;
   int    misses  = 0;
   string cur_req = "R1";
   bit    finished = 1'b0;

   // behavioural reference
   typedef enum {M_IDLE, M_OPEN, M_CBR} mst_t;
   typedef struct packed {
      logic r; logic c; logic w; logic [ADDR_W-1:0] a; logic d;
   } smp_t;

   mst_t            mst = M_IDLE;
   int              mrow = 0, mref = 0;
   logic [COLS-1:0] mbuf;
   logic [COLS-1:0] mm [int];
   logic            pr = 1'b1, pc = 1'b1, e_oe = 1'b0, e_do = 1'b0;
   smp_t            q [$];

   function automatic void model_step(smp_t s);
      bit rf = pr & ~s.r;
      bit rr = ~pr & s.r;
      bit cf = pc & ~s.c;
      bit cr = ~pc & s.c;
      int col = int'(s.a[COL_BITS-1:0]);
      case (mst)
         M_IDLE: begin
            e_oe = 1'b0; e_do = 1'b0;
            if (rf) begin
               mrow = s.c ? int'(s.a[ROW_BITS-1:0]) : mref;
               mbuf = mm.exists(mrow) ? mm[mrow] : 'x;
               mst  = s.c ? M_OPEN : M_CBR;
            end
         end
         M_OPEN: begin
            if (rr) begin
               mm[mrow] = mbuf; mst = M_IDLE; e_oe = 1'b0; e_do = 1'b0;
            end else if (cf) begin
               if (!s.w) begin
                  mbuf[col] = s.d; e_oe = 1'b0; e_do = 1'b0;
               end else begin
                  e_do = mbuf[col]; e_oe = 1'b1;
               end
            end else if (cr) begin
               e_oe = 1'b0; e_do = 1'b0;
            end
         end
         M_CBR: begin
            e_oe = 1'b0; e_do = 1'b0;
            if (s.r && s.c) begin
               mm[mrow] = mbuf; mref = (mref + 1) % ROWS; mst = M_IDLE;
            end
         end
         default: mst = M_IDLE;
      endcase
      pr = s.r; pc = s.c;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mst = M_IDLE; mref = 0; pr = 1'b1; pc = 1'b1;
         e_oe = 1'b0; e_do = 1'b0; q.delete();
      end else begin
         q.push_back('{ras_n, cas_n, we_n, addr, din});
         if (q.size() > SYNC) model_step(q.pop_front());
      end
   end

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         vectors++;
         if (dout_en !== e_oe) begin
            misses++;
            $display("FAIL %s per-cycle dout_en: got %b expected %b", cur_req, dout_en, e_oe);
         end else if (!dout_en && dout !== 1'b0) begin
            misses++;
            $display("FAIL R5 per-cycle dout while disabled: got %b expected 0", dout);
         end else if (e_oe && !$isunknown(e_do) && dout !== e_do) begin
            misses++;
            $display("FAIL %s per-cycle dout: got %b expected %b", cur_req, dout, e_do);
         end
      end
   end

   task automatic expect_port(string req, logic eoe, logic edo);
      vectors++;
      if (dout_en !== eoe || dout !== edo) begin
         misses++;
         $display("FAIL %s port check: got en=%b dout=%b expected en=%b dout=%b",
                  req, dout_en, dout, eoe, edo);
      end
   endtask

   task automatic settle();
      repeat (SYNC + 2) @(negedge clk);
   endtask

   task automatic open_row(int r);
      addr = ADDR_W'(r); ras_n = 1'b0; settle();
      addr = ADDR_W'($urandom);   // R2: bus changes freely once latched
      settle();
   endtask

   task automatic close_row();
      cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; settle();
      expect_port("R5", 1'b0, 1'b0);
   endtask

   task automatic wr_col(int c, logic v);
      addr = ADDR_W'(c); din = v; we_n = 1'b0; cas_n = 1'b0; settle();
      expect_port("R4", 1'b0, 1'b0);
      cas_n = 1'b1; we_n = 1'b1; din = ~v; settle();
   endtask

   task automatic rd_col(string req, int c, logic v);
      addr = ADDR_W'(c); we_n = 1'b1; cas_n = 1'b0; settle();
      expect_port(req, 1'b1, v);
      cas_n = 1'b1; settle();
      expect_port("R5", 1'b0, 1'b0);
   endtask

   task automatic cbr_cycle();
      cas_n = 1'b0; settle();
      addr = ADDR_W'($urandom); ras_n = 1'b0; settle();
      expect_port("R9", 1'b0, 1'b0);
      ras_n = 1'b1; settle();
      cas_n = 1'b1; settle();
   endtask

   logic sh [2][16];

   initial begin
      repeat (5) @(negedge clk);
      cur_req = "R1";
      expect_port("R1", 1'b0, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      expect_port("R1", 1'b0, 1'b0);

      // R2 / R4 / R3 / R7: writes and in-row readback on one open row
      cur_req = "R4";
      open_row(5);
      wr_col(3, 1'b1);
      wr_col(7, 1'b0);
      wr_col(COLS-1, 1'b1);
      wr_col(10, 1'b1);
      cur_req = "R7";
      rd_col("R7", 10, 1'b1);
      rd_col("R3", 7, 1'b0);
      close_row();

      // another row must not disturb row 5
      cur_req = "R6";
      open_row(9);
      wr_col(3, 1'b0);
      wr_col(7, 1'b1);
      close_row();

      // R6 / R2: reopen row 5 and read back
      open_row(5);
      rd_col("R6", 3, 1'b1);
      rd_col("R2", COLS-1, 1'b1);
      rd_col("R6", 7, 1'b0);
      close_row();
      open_row(9);
      rd_col("R6", 3, 1'b0);
      rd_col("R6", 7, 1'b1);
      close_row();

      // R8: refresh by row strobe only
      cur_req = "R8";
      addr = ADDR_W'(5); ras_n = 1'b0; settle();
      expect_port("R8", 1'b0, 1'b0);
      ras_n = 1'b1; settle();
      open_row(5);
      rd_col("R8", 3, 1'b1);
      close_row();

      // R11: column pulses with no row open
      cur_req = "R11";
      for (int i = 0; i < 3; i++) begin
         addr = ADDR_W'(3); cas_n = 1'b0; repeat (SYNC + 3) @(negedge clk);
         expect_port("R11", 1'b0, 1'b0);
         cas_n = 1'b1; settle();
      end

      // R9: counter-driven refresh with junk address
      cur_req = "R9";
      cbr_cycle();
      open_row(5);
      rd_col("R9", 3, 1'b1);
      close_row();

      // R10: full wrap of the refresh counter keeps data intact
      cur_req = "R10";
      for (int i = 0; i < ROWS + 4; i++) cbr_cycle();
      open_row(5);
      rd_col("R10", 3, 1'b1);
      rd_col("R10", COLS-1, 1'b1);
      close_row();
      open_row(9);
      rd_col("R10", 7, 1'b1);
      close_row();

      // R7: random page traffic on two rows
      cur_req = "R7";
      for (int r = 0; r < 2; r++) begin
         open_row(20 + r);
         for (int c = 0; c < 16; c++) begin
            sh[r][c] = 1'($urandom);
            wr_col(c, sh[r][c]);
         end
         for (int k = 0; k < 20; k++) begin
            int c = int'($urandom_range(15, 0));
            if ($urandom_range(1, 0) == 1) begin
               sh[r][c] = ~sh[r][c];
               wr_col(c, sh[r][c]);
            end else begin
               rd_col("R7", c, sh[r][c]);
            end
         end
         close_row();
      end
      for (int r = 0; r < 2; r++) begin
         open_row(20 + r);
         for (int c = 0; c < 16; c++) rd_col("R6", c, sh[r][c]);
         close_row();
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         misses++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

endmodule